// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block is the single source of system reset. It combines three causes into one reset that is brought out in both polarities. The first cause is the power-on reset input. The second is a supply-good flag from an external comparator. The third is a watchdog that software must service over the two-wire serial bus. The supervisor samples SDA and SCL on its own fast clock and watches for bus framing events. A start condition that is later closed by a stop condition counts as proof of life and restarts the watchdog.

All durations are measured in ticks of one timebase. A generate-time parameter selects where the ticks come from: either an external millisecond strobe, or an internal divider of the system clock. The hold time and the three watchdog periods are parameters in ticks, so a system can use real millisecond values and a bench can use small ones. The 2-bit period code comes from a neighbouring register block, and one of its values switches the watchdog off. While reset is active, a bus-inhibit output tells that register block to drop any command in progress.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_ni` is low, and afterwards until `HOLD_TICKS` ticks have passed with the supply good, `rst_o` is 1.
- R2: When `supply_ok_i` is 0, reset is active in that same cycle. It stays active until `HOLD_TICKS` consecutive ticks of good supply have passed. A new dip during the hold starts the hold over.
- R3: `bus_inhibit_o` is 1 exactly when reset is active.
- R4: Period code 2'b11 switches the watchdog off. With that code, reset never asserts however long the bus stays idle.
- R5: If no restart arrives in time, the watchdog expires and reset is active for `HOLD_TICKS` ticks. The time allowed is `WD_LONG_TICKS` for code 2'b00, `WD_MID_TICKS` for code 2'b01 and `WD_SHORT_TICKS` for code 2'b10.
- R6: The watchdog restarts on a stop (SDA rises while the synchronised SCL is high) only if a start (SDA falls while SCL is high) came after the previous restart. SDA moving while SCL is low is neither a start nor a stop.
- R7: The watchdog never expires while reset is active. Its count begins again from zero when a reset pulse ends.
- R8: Any change of the period code restarts the watchdog count from zero.
- R9: `rst_no` is always the inverse of `rst_o`.
- R10: The timebase is `tick_i` when `USE_EXT_TICK` is 1. Otherwise it is one tick every `DIV_CYCLES` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low |
| tick_i | input | 1 | External timebase strobe, one cycle wide |
| supply_ok_i | input | 1 | Supply above trip level, from comparator |
| sda_i | input | 1 | Serial data line, sampled only |
| scl_i | input | 1 | Serial clock line, sampled only |
| wd_code_i | input | 2 | Watchdog period code |
| rst_no | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |
| bus_inhibit_o | output | 1 | Abort request to the register block |

## Verification
The assertions assume that `supply_ok_i` and `wd_code_i` are already synchronous to `clk_i` and change only between edges. They also assume that SDA and SCL never switch in the same cycle, as on a real bus. The bench drives every input 1 ns after a rising edge, and it spaces bus line changes two cycles apart. Because the divider phase is not known to the bench, every timing check is placed at the early or late edge of a window one tick wide. The check therefore holds for any phase.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_code_e;

  // Timeout length in ticks for a period code; 0 means the watchdog is off.
  function automatic int unsigned period_ticks(logic [1:0] code,
                                               int unsigned t_long,
                                               int unsigned t_mid,
                                               int unsigned t_short);
    case (code)
      WD_LONG:  return t_long;
      WD_MID:   return t_mid;
      WD_SHORT: return t_short;
      default:  return 0;
    endcase
  endfunction

  function automatic bit code_enabled(logic [1:0] code);
    return code != WD_OFF;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Counter width able to hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned cnt_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sup_timebase.sv
module sup_timebase #(
  parameter bit          USE_EXT_TICK = 1'b1,
  parameter int unsigned DIV_CYCLES   = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic tick_o
);

  generate
    if (USE_EXT_TICK) begin : g_ext
      logic unused_ext;
      assign unused_ext = ^{clk_i, rst_ni};
      assign tick_o     = tick_i;
    end else begin : g_div
      localparam int unsigned DW = sup_pkg::cnt_width(DIV_CYCLES);
      localparam logic [DW-1:0] LAST = DW'(DIV_CYCLES - 1);
      logic [DW-1:0] div_q;
      logic          unused_tick;
      assign unused_tick = tick_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end

      assign tick_o = (div_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/sup_bus_events.sv
module sup_bus_events #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  output logic start_o,
  output logic stop_o,
  output logic kick_o
);

  localparam int unsigned LASTS = SYNC_STAGES - 1;

  logic [LASTS:0] sda_sh, scl_sh;
  logic           sda_s, scl_s, sda_prev;
  logic           armed_q;

  // Idle bus lines are high, so the synchronisers reset to ones.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_sh   <= '1;
      scl_sh   <= '1;
      sda_prev <= 1'b1;
    end else begin
      sda_sh   <= {sda_sh[LASTS-1:0], sda_i};
      scl_sh   <= {scl_sh[LASTS-1:0], scl_i};
      sda_prev <= sda_s;
    end
  end

  assign sda_s = sda_sh[LASTS];
  assign scl_s = scl_sh[LASTS];

  assign start_o = scl_s &  sda_prev & ~sda_s;
  assign stop_o  = scl_s & ~sda_prev &  sda_s;

  // A stop only counts when a start has been seen since the last restart.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (start_o) armed_q <= 1'b1;
    else if (stop_o)  armed_q <= 1'b0;
  end

  assign kick_o = stop_o & armed_q;

endmodule

// File: rtl/sup_hold_ctrl.sv
module sup_hold_ctrl #(
  parameter int unsigned HOLD_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic trigger_i,
  output logic busy_o
);

  localparam int unsigned HW = sup_pkg::cnt_width(HOLD_TICKS);
  localparam logic [HW-1:0] LAST = HW'(HOLD_TICKS - 1);

  logic [HW-1:0] cnt_q;
  logic          busy_q;
  logic          restart_hold;
  logic          hold_done;

  assign restart_hold = ~supply_ok_i | trigger_i;
  assign hold_done    = busy_q & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (restart_hold) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_done) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && tick_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int unsigned T_LONG  = 1400,
  parameter int unsigned T_MID   = 600,
  parameter int unsigned T_SHORT = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       hold_i,
  input  logic       kick_i,
  input  logic [1:0] code_i,
  output logic       expire_o
);

  localparam int unsigned MAXP = sup_pkg::max3(T_LONG, T_MID, T_SHORT);
  localparam int unsigned CW   = sup_pkg::cnt_width(MAXP + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic [1:0]    code_q;
  logic          code_chg;
  logic          enabled;
  logic          run;

  assign lim      = CW'(sup_pkg::period_ticks(code_i, T_LONG, T_MID, T_SHORT) - 1);
  assign enabled  = sup_pkg::code_enabled(code_i);
  assign code_chg = (code_i != code_q);
  assign run      = enabled & ~hold_i & ~kick_i & ~code_chg;
  assign expire_o = run & tick_i & (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= sup_pkg::WD_OFF;
      cnt_q  <= '0;
    end else begin
      code_q <= code_i;
      if (!run)          cnt_q <= '0;
      else if (expire_o) cnt_q <= '0;
      else if (tick_i)   cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter bit          USE_EXT_TICK   = 1'b1,
  parameter int unsigned DIV_CYCLES     = 1000,
  parameter int unsigned HOLD_TICKS     = 200,
  parameter int unsigned WD_LONG_TICKS  = 1400,
  parameter int unsigned WD_MID_TICKS   = 600,
  parameter int unsigned WD_SHORT_TICKS = 200,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       supply_ok_i,
  input  logic       sda_i,
  input  logic       scl_i,
  input  logic [1:0] wd_code_i,
  output logic       rst_no,
  output logic       rst_o,
  output logic       bus_inhibit_o
);

  // Named internal events, observed by the bound checker.
  logic tick;
  logic start_det;
  logic stop_det;
  logic wd_kick;
  logic wd_expire;
  logic hold_busy;
  logic rst_act;

  sup_timebase #(
    .USE_EXT_TICK (USE_EXT_TICK),
    .DIV_CYCLES   (DIV_CYCLES)
  ) u_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .tick_o (tick)
  );

  sup_bus_events #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_bus_events (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sda_i   (sda_i),
    .scl_i   (scl_i),
    .start_o (start_det),
    .stop_o  (stop_det),
    .kick_o  (wd_kick)
  );

  sup_hold_ctrl #(
    .HOLD_TICKS (HOLD_TICKS)
  ) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .supply_ok_i (supply_ok_i),
    .trigger_i   (wd_expire),
    .busy_o      (hold_busy)
  );

  sup_watchdog #(
    .T_LONG  (WD_LONG_TICKS),
    .T_MID   (WD_MID_TICKS),
    .T_SHORT (WD_SHORT_TICKS)
  ) u_watchdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .hold_i   (rst_act),
    .kick_i   (wd_kick),
    .code_i   (wd_code_i),
    .expire_o (wd_expire)
  );

  // A low supply reaches the outputs without waiting for a clock edge.
  assign rst_act       = hold_busy | ~supply_ok_i;
  assign rst_o         = rst_act;
  assign rst_no        = ~rst_act;
  assign bus_inhibit_o = rst_act;

endmodule

// File: rtl/sup_checker.sv
module sup_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       supply_ok_i,
  input logic [1:0] wd_code_i,
  input logic       rst_o,
  input logic       tick,
  input logic       start_det,
  input logic       stop_det,
  input logic       wd_kick,
  input logic       wd_expire
);

  assert_supply_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |-> rst_o);

  assert_hold_after_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> rst_o);

  assert_release_on_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> $past(tick));

  assert_off_never_expires_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire |-> (wd_code_i != 2'b11));

  assert_expire_resets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire |=> rst_o);

  assert_kick_on_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_kick |-> stop_det);

  assert_start_stop_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_det && stop_det));

  assert_no_expire_in_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire |-> !rst_o);

endmodule

bind rst_supervisor sup_checker i_sup_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .supply_ok_i (supply_ok_i),
  .wd_code_i   (wd_code_i),
  .rst_o       (rst_o),
  .tick        (tick),
  .start_det   (start_det),
  .stop_det    (stop_det),
  .wd_kick     (wd_kick),
  .wd_expire   (wd_expire)
);

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int D  = 4;   // clocks per tick
  localparam int H  = 5;   // hold ticks
  localparam int LL = 30;  // code 00
  localparam int LM = 20;  // code 01
  localparam int LS = 10;  // code 10

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply;
  logic       sda, scl;
  logic [1:0] code;
  logic       rst_no, rst_o, inh;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int    exp_cyc[$];
  bit    exp_val[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rst_supervisor #(
    .USE_EXT_TICK   (1'b0),
    .DIV_CYCLES     (D),
    .HOLD_TICKS     (H),
    .WD_LONG_TICKS  (LL),
    .WD_MID_TICKS   (LM),
    .WD_SHORT_TICKS (LS),
    .SYNC_STAGES    (2)
  ) i_rst_supervisor (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .tick_i        (1'b0),
    .supply_ok_i   (supply),
    .sda_i         (sda),
    .scl_i         (scl),
    .wd_code_i     (code),
    .rst_no        (rst_no),
    .rst_o         (rst_o),
    .bus_inhibit_o (inh)
  );

  // Monitor: every compare also covers R3 (inhibit) and R9 (polarity).
  always @(negedge clk) begin
    for (int i = exp_cyc.size() - 1; i >= 0; i--) begin
      if (exp_cyc[i] == cyc) begin
        n_cmp++;
        if (rst_o !== exp_val[i] || rst_no !== ~exp_val[i] || inh !== exp_val[i]) begin
          n_bad++;
          $display("FAIL %s (R3/R9 also): rst_o=%b rst_no=%b inhibit=%b expected rst_o=%b rst_no=%b inhibit=%b",
                   exp_tag[i], rst_o, rst_no, inh, exp_val[i], ~exp_val[i], exp_val[i]);
        end
        exp_cyc.delete(i);
        exp_val.delete(i);
        exp_tag.delete(i);
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_at(int d, bit v, string tag);
    exp_cyc.push_back(cyc + d);
    exp_val.push_back(v);
    exp_tag.push_back(tag);
  endtask

  task automatic drain();
    while (exp_cyc.size() != 0) step(1);
  endtask

  // Start then stop; k is the cycle in which SDA rose.
  task automatic bus_restart(output int k);
    sda = 1'b0; step(2);
    scl = 1'b0; step(2);
    scl = 1'b1; step(2);
    sda = 1'b1; k = cyc;
    step(1);
  endtask

  // SDA falls with SCL low, then a stop: no start precedes it.
  task automatic lone_stop();
    scl = 1'b0; step(2);
    sda = 1'b0; step(2);
    scl = 1'b1; step(2);
    sda = 1'b1; step(2);
  endtask

  // Window checks for an expiry counted from cycle k; lat = cycles until the count clears.
  task automatic expect_expiry(int k, int lat, int len, string tag);
    int off;
    off = k - cyc;
    expect_at(off + lat + (len - 1) * D,     1'b0, {tag, " R5 not yet expired"});
    expect_at(off + lat + len * D + 2,       1'b1, {tag, " R5 expired"});
    expect_at(off + lat + (len - 1 + H) * D, 1'b1, {tag, " R7 pulse still held"});
    expect_at(off + lat + 1 + (len + H) * D, 1'b0, {tag, " R7 pulse ended"});
  endtask

  task automatic run_expiry(logic [1:0] c, int len, string tag);
    int k;
    code = c; step(2);
    bus_restart(k);
    expect_expiry(k, 3, len, tag);
    drain();
    code = 2'b11; step(4);
  endtask

  initial begin
    int k;
    rst_n = 1'b0; supply = 1'b1; code = 2'b11; sda = 1'b1; scl = 1'b1;
    step(2);
    expect_at(1, 1'b1, "R1 asserted during power-on reset");
    step(3);
    rst_n = 1'b1;
    expect_at(16, 1'b1, "R1 held after power-up (R10 divider timebase)");
    expect_at(21, 1'b0, "R1 released after hold (R10 divider timebase)");
    drain();

    for (int j = 0; j < 4; j++) begin
      expect_at(50, 1'b0, "R4 watchdog off, no reset");
      step(50);
    end
    drain();

    supply = 1'b0;
    expect_at(1, 1'b1, "R2 supply low asserts at once");
    expect_at(9, 1'b1, "R2 held while supply low");
    step(10);
    supply = 1'b1;
    expect_at(16, 1'b1, "R2 held after supply returns");
    expect_at(21, 1'b0, "R2 released after hold");
    drain();

    supply = 1'b0; step(5);
    supply = 1'b1; step(8);
    supply = 1'b0;
    expect_at(1, 1'b1, "R2 dip during hold asserts");
    step(2);
    supply = 1'b1;
    expect_at(16, 1'b1, "R2 dip restarts hold");
    expect_at(21, 1'b0, "R2 release after restarted hold");
    drain();

    run_expiry(2'b10, LS, "code10");
    run_expiry(2'b01, LM, "code01");
    run_expiry(2'b00, LL, "code00");

    code = 2'b10; step(2);
    for (int j = 0; j < 6; j++) begin
      bus_restart(k);
      expect_at(19, 1'b0, "R6 restarts keep reset released");
      step(17);
    end
    drain();
    code = 2'b11; step(4);

    code = 2'b10; step(2);
    bus_restart(k);
    expect_expiry(k, 3, LS, "R6 lone stop ignored");
    lone_stop();
    drain();
    code = 2'b11; step(4);

    code = 2'b01; step(2);
    bus_restart(k);
    step(40);
    code = 2'b10;
    expect_expiry(cyc, 1, LS, "R8 code change restarts count");
    drain();
    code = 2'b11; step(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule